// File: doc/BRIEF.md
# Programmable Three-Input Logic Cell

The cell evaluates any Boolean function of three single-bit operands. An 8-bit truth word holds one output bit for each operand combination. Each of the three operand slots picks its source through its own select code: one of the external signal lines, or the cell's own output delayed by one clock. With its output fed back, a suitable truth word turns the cell into a state-holding element such as a set/clear latch. With independent operands, the cell is plain combinational glue such as a three-way parity function.

An optional output filter hides short glitches. These arise when operands that should change together reach the cell in different cycles. While the filter is enabled, the output moves to a new value only after that value has held for two consecutive clock edges. All pins are plain level signals: the configuration write is a single-cycle strobe, and the operand selects and external lines are static or free-running levels. The cell has no streaming data path, so no port carries a valid/ready handshake.

Top module: `lut3_cell`

## Requirements
- R1: When the filter is disabled, `lut_out` equals `truth[idx]` in the same cycle. `idx` is the 3-bit value formed from the three selected operands.
- R2: The index is formed as {operand 2, operand 1, operand 0}, with operand 2 as the most significant bit. Truth word 0x10 therefore gives 1 only when operand 2 is 1 and the other two operands are 0.
- R3: Select code k, for k below NUM_EXT, picks `ext_in[k]`. Code NUM_EXT picks the feedback bit. Any larger code gives a constant 0.
- R4: The feedback bit is `lut_out` as it was in the previous clock cycle, taken through one flip-flop.
- R5: Use truth word 0x32, with operand 2 as set, operand 1 as clear and operand 0 as feedback. Set alone drives the output to 1 from the next cycle, and clear alone drives it to 0. With neither input active, the output holds its value. With both inputs active, the output is forced to 0.
- R6: Truth word 0x96 makes the output the XOR of the three operands.
- R7: While the filter is enabled, a new raw value reaches `lut_out` on the second clock edge at which that value has been sampled.
- R8: While the filter is enabled, a raw pulse that lasts one cycle does not appear on `lut_out`.
- R9: Synchronous reset clears the truth word, the filter enable, the filter state and the feedback flop to 0, so `lut_out` is 0.
- R10: With the filter disabled, a change in an operand appears on `lut_out` in the same cycle, with no clock edge in between.
- R11: The truth word and the filter enable change only on a clock edge with `cfg_we` high. Values on `cfg_truth` or `cfg_filt_en` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Loads the truth word and the filter enable |
| cfg_truth | input | 8 | Truth word to load |
| cfg_filt_en | input | 1 | Filter enable to load |
| sel_in0 | input | SEL_W | Source select for operand 0 (index LSB) |
| sel_in1 | input | SEL_W | Source select for operand 1 |
| sel_in2 | input | SEL_W | Source select for operand 2 (index MSB) |
| ext_in | input | NUM_EXT | External signal lines |
| lut_out | output | 1 | Cell output |

## Verification
The hardest state to reach from the ports is a latch state that comes only from feedback. In it, the output is held purely by the looped-back flop while both external operands are idle, and the filter must not distort that loop. The bench programs 0x32 with operand 0 on the feedback select and pulses set and clear in separate cycles. It then pulses them together and afterwards holds both idle for several cycles, so that hold, forced-low and recovery are each observed. A behavioural model tracks the feedback and filter history every cycle, so that filtered latch operation and single-cycle pulses are compared exactly.

// File: rtl/lut3_pkg.sv
package lut3_pkg;
  localparam int unsigned LUT_OPERANDS = 3;
  localparam int unsigned TRUTH_W      = 1 << LUT_OPERANDS;
  typedef logic [TRUTH_W-1:0]      truth_t;
  typedef logic [LUT_OPERANDS-1:0] lut_idx_t;
endpackage

// File: rtl/lut3_src_mux.sv
module lut3_src_mux #(
  parameter int unsigned NUM_EXT = 4,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EXT-1:0] ext,
  input  logic               fb,
  output logic               operand
);
  localparam int unsigned POOL_N = 1 << SEL_W;

  logic [POOL_N-1:0] pool;

  always_comb begin
    pool              = '0;
    pool[NUM_EXT-1:0] = ext;
    pool[NUM_EXT]     = fb;
    operand           = pool[sel];
  end
endmodule

// File: rtl/lut3_glitch_filter.sv
module lut3_glitch_filter #(
  parameter int unsigned STABLE_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned HIST_W = (STABLE_LEN > 1) ? STABLE_LEN - 1 : 1;

  logic [HIST_W-1:0] hist_q;
  logic              filt_q;
  logic              settled;

  generate
    if (STABLE_LEN > 1) begin : g_hist
      assign settled = raw_i ? (&hist_q) : ~(|hist_q);
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else if (HIST_W == 1) hist_q <= raw_i;
        else hist_q <= {hist_q[HIST_W-2:0], raw_i};
      end
    end else begin : g_nohist
      assign settled = 1'b1;
      always_ff @(posedge clk) hist_q <= '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          filt_q <= 1'b0;
    else if (settled) filt_q <= raw_i;
  end

  assign filt_o = filt_q;

  assert_filt_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (filt_q != $past(filt_q))) |-> (filt_q == $past(raw_i)));

  assert_filt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (filt_q == 1'b0));
endmodule

// File: rtl/lut3_cell.sv
module lut3_cell
  import lut3_pkg::*;
#(
  parameter int unsigned NUM_EXT    = 4,
  parameter int unsigned STABLE_LEN = 2,
  localparam int unsigned SEL_W     = $clog2(NUM_EXT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_truth,
  input  logic               cfg_filt_en,
  input  logic [SEL_W-1:0]   sel_in0,
  input  logic [SEL_W-1:0]   sel_in1,
  input  logic [SEL_W-1:0]   sel_in2,
  input  logic [NUM_EXT-1:0] ext_in,
  output logic               lut_out
);
  truth_t     truth_q;
  logic       filt_en_q;
  logic       fb_q;
  lut_idx_t   idx;
  logic       raw;
  logic       filt;
  logic [SEL_W-1:0] sel_arr [LUT_OPERANDS];

  assign sel_arr[0] = sel_in0;
  assign sel_arr[1] = sel_in1;
  assign sel_arr[2] = sel_in2;

  always_ff @(posedge clk) begin
    if (rst) begin
      truth_q   <= '0;
      filt_en_q <= 1'b0;
    end else if (cfg_we) begin
      truth_q   <= cfg_truth;
      filt_en_q <= cfg_filt_en;
    end
  end

  generate
    for (genvar g = 0; g < LUT_OPERANDS; g++) begin : g_src
      lut3_src_mux #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_mux (
        .sel     (sel_arr[g]),
        .ext     (ext_in),
        .fb      (fb_q),
        .operand (idx[g])
      );
    end
  endgenerate

  assign raw = truth_q[idx];

  lut3_glitch_filter #(.STABLE_LEN(STABLE_LEN)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw),
    .filt_o (filt)
  );

  assign lut_out = filt_en_q ? filt : raw;

  always_ff @(posedge clk) begin
    if (rst) fb_q <= 1'b0;
    else     fb_q <= lut_out;
  end

  assert_fb_delay_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fb_q == $past(lut_out)));

  assert_truth_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_we)) |-> ($stable(truth_q) && $stable(filt_en_q)));

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (truth_q == '0 && fb_q == 1'b0 && !filt_en_q));
endmodule

// File: tb/lut3_cell_tb.sv
module lut3_cell_tb;
  localparam int NUM_EXT = 4;
  localparam int SEL_W   = 3;
  localparam int FB_SEL  = NUM_EXT;

  logic clk = 1'b0;
  logic rst, cfg_we, cfg_filt_en;
  logic [7:0] cfg_truth;
  logic [SEL_W-1:0] sel_in0, sel_in1, sel_in2;
  logic [NUM_EXT-1:0] ext_in;
  logic lut_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int m_truth, m_en, m_fb, m_hist, m_filt;

  always #2 clk = ~clk;

  lut3_cell u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_truth(cfg_truth),
    .cfg_filt_en(cfg_filt_en), .sel_in0(sel_in0), .sel_in1(sel_in1),
    .sel_in2(sel_in2), .ext_in(ext_in), .lut_out(lut_out)
  );

  function automatic int pick(int s);
    if (s < NUM_EXT) return int'(ext_in[s]);
    if (s == FB_SEL) return m_fb;
    return 0;
  endfunction

  function automatic int raw_exp();
    int i;
    i = pick(int'(sel_in2)) * 4 + pick(int'(sel_in1)) * 2 + pick(int'(sel_in0));
    return (m_truth >> i) & 1;
  endfunction

  function automatic int out_exp();
    return (m_en != 0) ? m_filt : raw_exp();
  endfunction

  task automatic check(string tag);
    int e;
    e = out_exp();
    tests++;
    if (int'(lut_out) != e) begin
      fails++;
      $display("FAIL %s: lut_out=%0d expected %0d at %0t", tag, lut_out, e, $time);
    end
  endtask

  // Inputs are already applied; compare mid-cycle, then advance model over the edge.
  task automatic step(string tag);
    int r, o;
    #1;
    check(tag);
    r = raw_exp();
    o = out_exp();
    @(posedge clk);
    if (rst) begin
      m_truth = 0; m_en = 0; m_fb = 0; m_hist = 0; m_filt = 0;
    end else begin
      m_fb = o;
      if (r == m_hist) m_filt = r;
      m_hist = r;
      if (cfg_we) begin
        m_truth = int'(cfg_truth);
        m_en    = int'(cfg_filt_en);
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg(int t, int en);
    cfg_truth = 8'(t); cfg_filt_en = en[0]; cfg_we = 1'b1;
    step("R11");
  endtask

  initial begin
    #150000;
    fails++;
    tests++;
    $display("FAIL watchdog: expired, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_truth = 0; m_en = 0; m_fb = 0; m_hist = 0; m_filt = 0;
    rst = 1'b1; cfg_we = 1'b0; cfg_truth = 8'hFF; cfg_filt_en = 1'b1;
    sel_in0 = 3'd0; sel_in1 = 3'd1; sel_in2 = 3'd2; ext_in = 4'hF;
    @(negedge clk);
    step("R9"); step("R9");
    rst = 1'b0;
    step("R9");
    // R11: values on cfg pins without strobe
    cfg_truth = 8'hFF; cfg_filt_en = 1'b0;
    for (int k = 0; k < 4; k++) begin ext_in = 4'(k * 3); step("R11"); end
    // R6: xor over all combos
    cfg(8'h96, 0);
    for (int k = 0; k < 8; k++) begin ext_in = 4'(k); step("R6"); end
    // R2: index order
    cfg(8'h10, 0);
    for (int k = 0; k < 8; k++) begin ext_in = 4'(k); step("R2"); end
    // R10: same-cycle response, filter off
    ext_in = 4'b0100; #1 check("R10");
    ext_in = 4'b0101; #1 check("R10");
    step("R10");
    // R3: select codes incl. feedback and out-of-range
    cfg(8'hAA, 0);
    for (int s = 0; s < 8; s++) begin
      sel_in0 = 3'(s);
      for (int k = 0; k < 2; k++) begin ext_in = 4'((s + k) * 5); step("R3"); end
    end
    // R5 / R4: latch from feedback
    sel_in0 = 3'(FB_SEL); sel_in1 = 3'd1; sel_in2 = 3'd0;
    cfg(8'h32, 0);
    ext_in = 4'b0000; step("R5"); step("R4");
    ext_in = 4'b0001; step("R5");
    ext_in = 4'b0000; step("R5"); step("R4"); step("R5");
    ext_in = 4'b0010; step("R5");
    ext_in = 4'b0000; step("R5"); step("R4");
    ext_in = 4'b0001; step("R5");
    ext_in = 4'b0011; step("R5");
    ext_in = 4'b0000; step("R5"); step("R5"); step("R4");
    // R7 / R8: filtered latch and filtered xor
    cfg(8'h32, 1);
    ext_in = 4'b0001; step("R7"); step("R7");
    ext_in = 4'b0000; step("R7"); step("R7"); step("R7");
    ext_in = 4'b0010; step("R8");
    ext_in = 4'b0000; step("R8"); step("R8"); step("R8");
    sel_in0 = 3'd0; sel_in1 = 3'd1; sel_in2 = 3'd2;
    cfg(8'h96, 1);
    ext_in = 4'b0001; step("R7"); step("R7"); step("R7");
    ext_in = 4'b0011; step("R8");
    ext_in = 4'b0001; step("R8"); step("R8"); step("R8");
    // R1: random operation
    for (int k = 0; k < 400; k++) begin
      if (k % 37 == 0) begin
        cfg_truth = 8'($urandom); cfg_filt_en = 1'($urandom); cfg_we = 1'b1;
      end
      sel_in0 = 3'($urandom % 6); sel_in1 = 3'($urandom % 6); sel_in2 = 3'($urandom % 6);
      ext_in = 4'($urandom);
      step("R1");
    end
    rst = 1'b1; step("R9");
    rst = 1'b0; step("R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule